// File: doc/BRIEF.md
# Four-Lane Neuron Processing Element

This block is a processing element that sits on a network port and evaluates up to four neurons side by side. After a configuration phase has filled each neuron's weight memory, the shared activation table and the header word, the block takes a stream of signed fixed-point inputs. Every enabled neuron multiplies each input by the weight at the same position in its own memory and adds the product into a saturating accumulator.

When the last input of a vector arrives, the block builds one outbound packet. The first word is the stored header, unchanged. One payload word follows for each selected neuron, in ascending neuron order. Each payload is the activation-table entry addressed by the upper bits of that neuron's sum. The block then returns to accepting the next vector with the same configuration.

A start-of-configuration pulse sends the block back to the configuration phase from any stage.

Top module: `neuron_pe_quad`

## Requirements
- R1: After reset, out_valid and calc_ready are 0. The block stays in the configuration stage, and inputs produce no output, until a header is written.
- R2: Data words are signed Q3.12. For each accepted input x_i, each enabled neuron adds the product x_i * w_i to its accumulator. The weight w_i is word i of that neuron's weight memory, with i counting from 0 at the start of the vector. The 24-fraction-bit product is rounded to 12 fraction bits as (p + 2048) >>> 12, with arithmetic shift.
- R3: After every addition the accumulator is saturated to the range -32768 to 32767. Later inputs continue from the saturated value.
- R4: A neuron's payload is the activation-table entry whose address is bits [15:8] of its sum, read as an unsigned value from 0 to 255.
- R5: Header bits [3:0] are the neuron mask, where bit k enables neuron k (for example 1100 selects the third and fourth neurons). Header bits [5:4] hold c, and at most c+1 payloads are sent. Payloads go out for enabled neurons in ascending order. The packet stops after c+1 payloads or when no enabled neuron remains. A mask of 0 gives a packet that holds only the header.
- R6: A packet is the stored header word, unchanged in all 16 bits, followed by the payloads. out_valid stays high on consecutive cycles for the whole packet, and out_last marks the final word.
- R7: Let the input carrying in_last be taken at clock edge t. The header appears on the outputs after edge t+1 and payload j after edge t+1+j. Each added neuron therefore costs one cycle.
- R8: Inputs are taken only while calc_ready is 1. Inputs presented at any other time have no effect. calc_ready falls at edge t and returns one edge after the final packet word. The next vector starts from zero sums and weight index 0.
- R9: Weight writes (cfg_we with cfg_lut=0, at cfg_neuron and cfg_addr[3:0]) and table writes (cfg_we with cfg_lut=1, at cfg_addr[7:0]) take effect only in the configuration stage and are ignored in any other stage. hdr_we in the configuration stage stores cfg_data as the header and enters the calculate stage. Outside that stage hdr_we is ignored.
- R10: A cfg_start pulse in any stage leaves the block, one edge later, in the configuration stage with out_valid=0 and its partial sums discarded. Weight and table contents are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_start | input | 1 | Return to configuration stage |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_lut | input | 1 | 1 selects the activation table, 0 a weight memory |
| cfg_neuron | input | 2 | Target neuron of a weight write |
| cfg_addr | input | 8 | Weight index or table address |
| cfg_data | input | 16 | Write data and header word |
| hdr_we | input | 1 | Store header and begin calculating |
| in_valid | input | 1 | Input word present |
| in_data | input | 16 | Q3.12 input word |
| in_last | input | 1 | Final input of the vector |
| calc_ready | output | 1 | Block is in the calculate stage |
| out_valid | output | 1 | Packet word present |
| out_data | output | 16 | Header or payload word |
| out_last | output | 1 | Final word of the packet |

## Verification
Counting from the edge that takes the final input, the bench expects out_valid to stay low at that edge. It expects the header one edge later, each payload on each edge after that, and calc_ready high again one edge after the last word. Inputs are driven and outputs sampled on falling edges, so each result is read half a period after the rising edge that produced it. The same falling-edge sampling is used to check that junk inputs held during emission, configuration writes outside the configuration stage, and a mid-vector restart leave the following packet as the model predicts.

// File: rtl/pe_pkg.sv
package pe_pkg;

   typedef enum logic [1:0] {
      ST_DECODE = 2'd0,
      ST_CALC   = 2'd1,
      ST_EMIT   = 2'd2
   } pe_stage_e;

endpackage

// File: rtl/pe_mac_lane.sv
module pe_mac_lane #(
   parameter int DW    = 16,
   parameter int FRAC  = 12,
   parameter int DEPTH = 16,
   parameter bit ROUND = 1'b1,
   localparam int IW   = $clog2(DEPTH)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [IW-1:0]        wr_addr,
   input  logic [DW-1:0]        wr_data,
   input  logic                 clr,
   input  logic                 fire,
   input  logic [IW-1:0]        rd_addr,
   input  logic signed [DW-1:0] x,
   output logic signed [DW-1:0] acc
);

   localparam int PW = 2 * DW;
   localparam logic signed [PW:0]   HI   = (PW+1)'(2 ** (DW - 1) - 1);
   localparam logic signed [PW:0]   LO   = (PW+1)'(-(2 ** (DW - 1)));
   localparam logic signed [PW-1:0] HALF = PW'(2 ** (FRAC - 1));

   logic signed [DW-1:0] wmem [DEPTH];
   logic signed [DW-1:0] w;
   logic signed [PW-1:0] prod, prod_q;
   logic signed [PW:0]   total;
   logic signed [DW-1:0] sat;

   always_ff @(posedge clk) begin
      if (wr_en) wmem[wr_addr] <= wr_data;
   end

   assign w    = wmem[rd_addr];
   assign prod = x * w;

   generate
      if (ROUND) begin : g_round
         assign prod_q = (prod + HALF) >>> FRAC;
      end else begin : g_trunc
         assign prod_q = prod >>> FRAC;
      end
   endgenerate

   assign total = (PW+1)'(acc) + (PW+1)'(prod_q);

   always_comb begin
      if (total > HI)      sat = HI[DW-1:0];
      else if (total < LO) sat = LO[DW-1:0];
      else                 sat = total[DW-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    acc <= '0;
      else if (clr)  acc <= '0;
      else if (fire) acc <= sat;
   end

   // R8
   acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!fire && !clr) |=> $stable(acc));

endmodule

// File: rtl/pe_act_lut.sv
module pe_act_lut #(
   parameter int AW = 8,
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [DW-1:0] wr_data,
   input  logic [AW-1:0] rd_addr,
   output logic [DW-1:0] rd_data
);

   logic [DW-1:0] table_q [2 ** AW];

   always_ff @(posedge clk) begin
      if (wr_en) table_q[wr_addr] <= wr_data;
   end

   assign rd_data = table_q[rd_addr];

endmodule

// File: rtl/neuron_pe_quad.sv
module neuron_pe_quad
   import pe_pkg::*;
#(
   parameter int DW     = 16,
   parameter int FRAC   = 12,
   parameter int NEUR   = 4,
   parameter int DEPTH  = 16,
   parameter int LUT_AW = 8,
   parameter bit ROUND  = 1'b1,
   localparam int CW    = $clog2(NEUR),
   localparam int IW    = $clog2(DEPTH),
   localparam int AW    = (LUT_AW > IW) ? LUT_AW : IW
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_start,
   input  logic          cfg_we,
   input  logic          cfg_lut,
   input  logic [CW-1:0] cfg_neuron,
   input  logic [AW-1:0] cfg_addr,
   input  logic [DW-1:0] cfg_data,
   input  logic          hdr_we,
   input  logic          in_valid,
   input  logic [DW-1:0] in_data,
   input  logic          in_last,
   output logic          calc_ready,
   output logic          out_valid,
   output logic [DW-1:0] out_data,
   output logic          out_last
);

   if (NEUR < 2 || NEUR > 4 || (NEUR & (NEUR - 1)) != 0) begin : g_bad_neur
      $error("NEUR must be 2 or 4");
   end
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("DEPTH must be a power of two");
   end
   if (DW < NEUR + CW || LUT_AW > DW || FRAC >= DW || FRAC < 1) begin : g_bad_width
      $error("header fields, table address or fraction do not fit DW");
   end

   pe_stage_e            stage_q;
   logic [DW-1:0]        hdr_q;
   logic [IW-1:0]        widx_q;
   logic                 first_q;
   logic [NEUR-1:0]      rem_q, rem_nx;
   logic [CW-1:0]        pcnt_q, sel;
   logic [NEUR-1:0]      mask;
   logic [CW-1:0]        cnt;
   logic                 in_go, clr, final_pay;
   logic signed [DW-1:0] acc [NEUR];
   logic [DW-1:0]        lut_rdata;
   logic                 in_decode;

   assign mask       = hdr_q[NEUR-1:0];
   assign cnt        = hdr_q[NEUR+CW-1:NEUR];
   assign in_decode  = (stage_q == ST_DECODE);
   assign calc_ready = (stage_q == ST_CALC);
   assign in_go      = calc_ready && in_valid && !cfg_start;
   assign clr        = cfg_start || (stage_q == ST_EMIT && out_valid && out_last);

   generate
      for (genvar k = 0; k < NEUR; k++) begin : g_lane
         pe_mac_lane #(
            .DW(DW), .FRAC(FRAC), .DEPTH(DEPTH), .ROUND(ROUND)
         ) u_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (cfg_we && !cfg_lut && in_decode && cfg_neuron == CW'(k)),
            .wr_addr (cfg_addr[IW-1:0]),
            .wr_data (cfg_data),
            .clr     (clr),
            .fire    (in_go && mask[k]),
            .rd_addr (widx_q),
            .x       (in_data),
            .acc     (acc[k])
         );
      end
   endgenerate

   always_comb begin
      sel = '0;
      for (int k = NEUR - 1; k >= 0; k--) begin
         if (rem_q[k]) sel = CW'(k);
      end
      rem_nx      = rem_q;
      rem_nx[sel] = 1'b0;
      final_pay   = (pcnt_q == cnt) || (rem_nx == '0);
   end

   pe_act_lut #(.AW(LUT_AW), .DW(DW)) u_lut (
      .clk     (clk),
      .wr_en   (cfg_we && cfg_lut && in_decode),
      .wr_addr (cfg_addr[LUT_AW-1:0]),
      .wr_data (cfg_data),
      .rd_addr (acc[sel][DW-1 -: LUT_AW]),
      .rd_data (lut_rdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage_q   <= ST_DECODE;
         hdr_q     <= '0;
         widx_q    <= '0;
         first_q   <= 1'b0;
         rem_q     <= '0;
         pcnt_q    <= '0;
         out_valid <= 1'b0;
         out_last  <= 1'b0;
         out_data  <= '0;
      end else if (cfg_start) begin
         stage_q   <= ST_DECODE;
         widx_q    <= '0;
         out_valid <= 1'b0;
         out_last  <= 1'b0;
      end else begin
         case (stage_q)
            ST_DECODE: begin
               if (hdr_we) begin
                  hdr_q   <= cfg_data;
                  stage_q <= ST_CALC;
                  widx_q  <= '0;
               end
            end
            ST_CALC: begin
               if (in_valid) begin
                  widx_q <= widx_q + 1'b1;
                  if (in_last) begin
                     stage_q <= ST_EMIT;
                     widx_q  <= '0;
                     first_q <= 1'b1;
                     rem_q   <= mask;
                     pcnt_q  <= '0;
                  end
               end
            end
            ST_EMIT: begin
               if (out_valid && out_last) begin
                  out_valid <= 1'b0;
                  out_last  <= 1'b0;
                  stage_q   <= ST_CALC;
               end else if (first_q) begin
                  out_valid <= 1'b1;
                  out_data  <= hdr_q;
                  out_last  <= (mask == '0);
                  first_q   <= 1'b0;
               end else begin
                  out_valid <= 1'b1;
                  out_data  <= lut_rdata;
                  out_last  <= final_pay;
                  rem_q     <= rem_nx;
                  pcnt_q    <= pcnt_q + 1'b1;
               end
            end
            default: stage_q <= ST_DECODE;
         endcase
      end
   end

   // R10
   cfg_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_start |=> (!calc_ready && !out_valid));

   // R6
   hdr_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !$past(out_valid)) |-> (out_data == hdr_q));

   // R6
   last_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_last |-> out_valid);

   // R8
   no_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !calc_ready);

endmodule

// File: tb/neuron_pe_quad_test.sv
module neuron_pe_quad_test;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        cfg_start, cfg_we, cfg_lut, hdr_we;
   logic [1:0]  cfg_neuron;
   logic [7:0]  cfg_addr;
   logic [15:0] cfg_data;
   logic        in_valid, in_last;
   logic [15:0] in_data;
   logic        calc_ready, out_valid, out_last;
   logic [15:0] out_data;

   int tests = 0;
   int fails = 0;
   bit done  = 1'b0;

   logic [15:0] bw [4][16];
   logic [15:0] blut [256];
   logic [15:0] vec [16];
   logic [15:0] cur_hdr;

   always #5 clk = ~clk;

   neuron_pe_quad uut (
      .clk(clk), .rst_n(rst_n), .cfg_start(cfg_start), .cfg_we(cfg_we),
      .cfg_lut(cfg_lut), .cfg_neuron(cfg_neuron), .cfg_addr(cfg_addr),
      .cfg_data(cfg_data), .hdr_we(hdr_we), .in_valid(in_valid),
      .in_data(in_data), .in_last(in_last), .calc_ready(calc_ready),
      .out_valid(out_valid), .out_data(out_data), .out_last(out_last)
   );

   function automatic logic [15:0] mac(input logic [15:0] acc, input logic [15:0] x,
                                       input logic [15:0] w);
      longint p, r, t;
      p = longint'($signed(x)) * longint'($signed(w));
      r = (p + 2048) >>> 12;
      t = longint'($signed(acc)) + r;
      if (t > 32767) t = 32767;
      else if (t < -32768) t = -32768;
      return t[15:0];
   endfunction

   function automatic logic [15:0] neuron_sum(input int n, input int len);
      logic [15:0] a;
      a = '0;
      for (int i = 0; i < len; i++) a = mac(a, vec[i], bw[n][i]);
      return a;
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic pulse_start();
      cfg_start = 1'b1;
      @(negedge clk);
      cfg_start = 1'b0;
   endtask

   task automatic put_w(input int n, input int a, input logic [15:0] d);
      cfg_we = 1'b1; cfg_lut = 1'b0; cfg_neuron = 2'(n); cfg_addr = 8'(a); cfg_data = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic load_w(input int n, input int a, input logic [15:0] d);
      bw[n][a] = d;
      put_w(n, a, d);
   endtask

   task automatic put_lut(input int a, input logic [15:0] d);
      cfg_we = 1'b1; cfg_lut = 1'b1; cfg_addr = 8'(a); cfg_data = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic put_hdr(input logic [15:0] h);
      hdr_we = 1'b1; cfg_data = h;
      @(negedge clk);
      hdr_we = 1'b0;
   endtask

   task automatic set_hdr(input logic [15:0] h);
      cur_hdr = h;
      put_hdr(h);
      chk("R9 header enters calculate", 32'(calc_ready), 32'd1);
   endtask

   task automatic run_vec(input int len, input string tag, input bit junk);
      logic [15:0] exp [5];
      logic [15:0] s;
      int n;
      exp[0] = cur_hdr;
      n = 0;
      for (int k = 0; k < 4; k++) begin
         if (cur_hdr[k] && n <= int'(cur_hdr[5:4])) begin
            s = neuron_sum(k, len);
            exp[1 + n] = blut[s[15:8]];
            n++;
         end
      end
      for (int i = 0; i < len; i++) begin
         in_valid = 1'b1; in_data = vec[i]; in_last = (i == len - 1);
         @(negedge clk);
      end
      if (junk) begin
         in_valid = 1'b1; in_data = 16'h7FFF; in_last = 1'b1;
      end else begin
         in_valid = 1'b0; in_last = 1'b0;
      end
      chk({tag, " R7 no word at last-input edge"}, 32'(out_valid), 32'd0);
      chk({tag, " R8 not ready while emitting"}, 32'(calc_ready), 32'd0);
      for (int j = 0; j <= n; j++) begin
         @(negedge clk);
         chk({tag, " R7 word valid"}, 32'(out_valid), 32'd1);
         chk({tag, (j == 0) ? " R6 header" : " R2 R4 R5 payload"}, 32'(out_data), 32'(exp[j]));
         chk({tag, " R6 last flag"}, 32'(out_last), 32'(j == n));
      end
      in_valid = 1'b0; in_last = 1'b0;
      @(negedge clk);
      chk({tag, " R6 packet ended"}, 32'(out_valid), 32'd0);
      chk({tag, " R8 ready again"}, 32'(calc_ready), 32'd1);
   endtask

   task automatic rand_vec(output int len);
      len = int'($urandom_range(1, 16));
      for (int i = 0; i < 16; i++) vec[i] = 16'($urandom);
   endtask

   initial begin
      int len;
      void'($urandom(32'd2024));
      rst_n = 1'b0; cfg_start = 1'b0; cfg_we = 1'b0; cfg_lut = 1'b0; hdr_we = 1'b0;
      cfg_neuron = '0; cfg_addr = '0; cfg_data = '0;
      in_valid = 1'b0; in_data = '0; in_last = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 reset out_valid", 32'(out_valid), 32'd0);
      chk("R1 reset calc_ready", 32'(calc_ready), 32'd0);
      in_valid = 1'b1; in_last = 1'b1; in_data = 16'h1234;
      repeat (4) @(negedge clk);
      chk("R1 no output before header", 32'(out_valid), 32'd0);
      in_valid = 1'b0; in_last = 1'b0;

      // configuration with random weights and distinct table entries
      for (int k = 0; k < 4; k++)
         for (int a = 0; a < 16; a++)
            load_w(k, a, 16'(int'($urandom_range(0, 8191)) - 4096));
      for (int a = 0; a < 256; a++) begin
         blut[a] = {8'(a), 8'(a) ^ 8'h5A};
         put_lut(a, blut[a]);
      end
      set_hdr({10'($urandom), 2'b11, 4'b1111});

      for (int r = 0; r < 6; r++) begin
         rand_vec(len);
         run_vec(len, "random all four", 1'b0);
      end

      // R9: writes outside the configuration stage are ignored
      put_w(0, 0, 16'h7FFF);
      put_lut(0, 16'hDEAD);
      put_hdr(16'h0031);
      for (int i = 0; i < 16; i++) vec[i] = 16'($urandom);
      run_vec(16, "R9 ignored writes", 1'b0);

      // R8: inputs during emission have no effect
      rand_vec(len);
      run_vec(len, "R8 junk held", 1'b1);
      rand_vec(len);
      run_vec(len, "R8 after junk", 1'b0);

      // R10: restart mid-vector, weights kept
      for (int i = 0; i < 3; i++) begin
         in_valid = 1'b1; in_data = 16'h7000; in_last = 1'b0;
         @(negedge clk);
      end
      in_valid = 1'b0;
      pulse_start();
      chk("R10 back in configuration", 32'(calc_ready), 32'd0);
      chk("R10 no output", 32'(out_valid), 32'd0);
      set_hdr(cur_hdr);
      rand_vec(len);
      run_vec(len, "R10 fresh sums", 1'b0);

      // R3: saturation per step
      pulse_start();
      for (int a = 0; a < 3; a++) begin
         load_w(0, a, 16'h7FFF);
         load_w(1, a, 16'h8000);
         load_w(2, a, 16'h1000);
         load_w(3, a, 16'h1000);
      end
      set_hdr({10'h2A5, 2'b10, 4'b0111});
      vec[0] = 16'h7000; vec[1] = 16'h7000; vec[2] = 16'h9000;
      run_vec(3, "R3 step saturation", 1'b0);
      vec[0] = 16'h7FFF; vec[1] = 16'h7FFF; vec[2] = 16'h7FFF;
      run_vec(3, "R3 rail values", 1'b0);

      // R2: rounding carries across a table bucket
      pulse_start();
      load_w(3, 0, 16'h00FF);
      load_w(3, 1, 16'h0800);
      load_w(2, 0, 16'hFF01);
      load_w(2, 1, 16'hF800);
      set_hdr({10'h133, 2'b00, 4'b1000});
      vec[0] = 16'h1000; vec[1] = 16'h0001;
      run_vec(2, "R2 round half up", 1'b0);
      chk("R2 rounded bucket", 32'(neuron_sum(3, 2)), 32'h0100);

      // R5: mask and count combinations
      pulse_start();
      set_hdr({10'h001, 2'b01, 4'b1100});
      vec[0] = 16'h1000; vec[1] = 16'h0001;
      run_vec(2, "R5 third and fourth", 1'b0);
      pulse_start();
      set_hdr({10'h3FF, 2'b01, 4'b1111});
      rand_vec(len);
      run_vec(len, "R5 count limits", 1'b0);
      pulse_start();
      set_hdr({10'h155, 2'b11, 4'b0010});
      rand_vec(len);
      run_vec(len, "R5 mask exhausted", 1'b0);
      pulse_start();
      set_hdr({10'h0F0, 2'b11, 4'b0000});
      rand_vec(len);
      run_vec(len, "R5 header only", 1'b0);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         tests++;
         fails++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

endmodule